// File: doc/BRIEF.md
# AHB Slave Retry Response Generator

This block is the bus-facing front end of an AHB slave whose storage sits behind a slow backend, for example a flash controller. It accepts a transfer, hands it to the backend over a level request, busy and done handshake, and decides how to answer the master. A quick backend is answered with ordinary wait states and then OKAY. If the backend cannot serve the transfer soon, the block ends it early with a two-cycle RETRY. The master then releases the bus, the arbiter can serve other masters, and the master reissues the transfer later.

Two conditions lead to RETRY. The backend reports busy in the cycle the transfer is addressed, or the data phase has stalled for longer than a programmable cycle limit. A configuration input turns both conditions off. In that mode the slave only inserts wait states, which suits low-latency use. Each accepted transfer starts with a cleared stall count, so a reissued transfer gets the full budget again.

Top module: `ahb_retry_slave`

## Requirements
- R1: A transfer is accepted only when `hsel` is 1, `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01) or unselected cycles leave `hreadyout` at 1 and `hresp` at OKAY (2'b00), and `be_req` is never raised.
- R2: When `cfg_retry_en` is 1 and `be_busy` is 1 in the accepting cycle, `be_req` stays 0. The first data-phase cycle shows `hresp` = RETRY (2'b10) with `hreadyout` = 0. The next cycle shows `hresp` = RETRY with `hreadyout` = 1.
- R3: Otherwise `be_req` is 1 from the first data-phase cycle, with `be_addr` equal to the captured `haddr`. `hreadyout` stays 0 with `hresp` = OKAY in every cycle in which `be_done` is 0.
- R4: In the data-phase cycle in which `be_done` is 1, `hreadyout` is 1, `hresp` is OKAY and `hrdata` equals `be_rdata`.
- R5: With `cfg_retry_en` = 1 and a limit L on `cfg_stall_limit`, at most L+1 OKAY wait-state cycles occur. If `be_done` has not arrived by then, the two-cycle RETRY of R2 follows immediately. A backend latency of exactly L+1 stall cycles ends in RETRY, and a latency of L ends in OKAY.
- R6: With `cfg_retry_en` = 0, `be_busy` is ignored and RETRY is never issued. Wait states continue until `be_done`, whatever their number.
- R7: The stall count restarts at every accepted transfer and every completed response. Back-to-back transfers and a transfer reissued after RETRY each get the full L+1 budget.
- R8: During the data phase, `be_write` equals the captured `hwrite` and `be_wdata` equals `hwdata`.
- R9: While `rst` is high and right after it, `hreadyout` is 1, `hresp` is OKAY and `be_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_retry_en | input | 1 | 1: busy and stall-limit retries enabled; 0: wait states only |
| cfg_stall_limit | input | CNT_W | Stall limit L; RETRY after L+1 stalled cycles |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Address phase address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 2 | Response code |
| hrdata | output | DATA_W | Read data |
| be_req | output | 1 | Backend request, held while waiting |
| be_addr | output | ADDR_W | Backend address |
| be_write | output | 1 | Backend write flag |
| be_wdata | output | DATA_W | Backend write data |
| be_busy | input | 1 | Backend internal operation in progress |
| be_done | input | 1 | Backend completes the request this cycle |
| be_rdata | input | DATA_W | Backend read data, valid with `be_done` |

## Verification
The accepting edge moves the block into its data phase, so `be_req`, `be_addr`, `be_write` and the first RETRY cycle are all due one cycle after the address phase. The bench samples them at the falling edge of that cycle. Completion is combinational on `be_done`: OKAY and `hrdata` appear in the same cycle the bench raises `be_done`. A stall-limit RETRY begins exactly L+1 stalled cycles into the data phase. A scoreboard monitor counts the OKAY wait cycles and the RETRY lead cycle of each transfer and compares them, together with the final response and data, against the item the driver queued. The driver computed that item from the configuration, the busy flag and the chosen backend latency.

// File: rtl/ahb_retry_pkg.sv
package ahb_retry_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // Data-phase progress of the slave
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RTY_LEAD,
        PH_RTY_TAIL
    } phase_e;

    // NONSEQ and SEQ both carry a set upper bit
    function automatic logic trans_is_active(input logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/ahb_retry_addr_capture.sv
module ahb_retry_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_write
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
    } addr_phase_t;

    addr_phase_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (accept) begin
            held_q <= '{addr: haddr, write: hwrite};
        end
    end

    assign cap_addr  = held_q.addr;
    assign cap_write = held_q.write;

endmodule

// File: rtl/ahb_retry_stall_cnt.sv
module ahb_retry_stall_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             limit_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // cnt_q counts the stalled cycles before the current one
    assign limit_hit = (cnt_q >= limit);

endmodule

// File: rtl/ahb_retry_ctrl.sv
module ahb_retry_ctrl
    import ahb_retry_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   cfg_retry_en,
    input  logic   be_busy,
    input  logic   be_done,
    input  logic   limit_hit,
    output phase_e phase,
    output logic   hreadyout,
    output logic   [1:0] hresp,
    output logic   be_req,
    output logic   cnt_clr,
    output logic   cnt_inc
);

    phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:     ph_d = PH_IDLE;
            PH_WAIT: begin
                if (be_done) begin
                    ph_d = PH_IDLE;
                end else if (cfg_retry_en && limit_hit) begin
                    ph_d = PH_RTY_LEAD;
                end
            end
            PH_RTY_LEAD: ph_d = PH_RTY_TAIL;
            PH_RTY_TAIL: ph_d = PH_IDLE;
            default:     ph_d = PH_IDLE;
        endcase
        if (accept) begin
            ph_d = (cfg_retry_en && be_busy) ? PH_RTY_LEAD : PH_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        hreadyout = 1'b1;
        hresp     = RESP_OKAY;
        be_req    = 1'b0;
        unique case (ph_q)
            PH_WAIT: begin
                be_req    = 1'b1;
                hreadyout = be_done;
            end
            PH_RTY_LEAD: begin
                hreadyout = 1'b0;
                hresp     = RESP_RETRY;
            end
            PH_RTY_TAIL: begin
                hresp     = RESP_RETRY;
            end
            default: ;
        endcase
    end

    assign phase   = ph_q;
    assign cnt_clr = accept || hreadyout;
    assign cnt_inc = (ph_q == PH_WAIT) && !be_done;

endmodule

// File: rtl/ahb_retry_slave.sv
module ahb_retry_slave
    import ahb_retry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_retry_en,
    input  logic [CNT_W-1:0]  cfg_stall_limit,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic [1:0]        hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              be_req,
    output logic [ADDR_W-1:0] be_addr,
    output logic              be_write,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_busy,
    input  logic              be_done,
    input  logic [DATA_W-1:0] be_rdata
);

    logic   accept;
    logic   cnt_clr, cnt_inc, limit_hit;
    phase_e phase;

    assign accept = hsel && hready && trans_is_active(htrans);

    ahb_retry_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .cap_addr  (be_addr),
        .cap_write (be_write)
    );

    ahb_retry_stall_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .limit     (cfg_stall_limit),
        .limit_hit (limit_hit)
    );

    ahb_retry_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .cfg_retry_en (cfg_retry_en),
        .be_busy      (be_busy),
        .be_done      (be_done),
        .limit_hit    (limit_hit),
        .phase        (phase),
        .hreadyout    (hreadyout),
        .hresp        (hresp),
        .be_req       (be_req),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc)
    );

    assign be_wdata = hwdata;
    assign hrdata   = (phase == PH_WAIT) ? be_rdata : '0;

endmodule

// File: rtl/ahb_retry_slave_chk.sv
module ahb_retry_slave_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_retry_en,
    input logic [CNT_W-1:0] cfg_stall_limit,
    input logic             hreadyout,
    input logic [1:0]       hresp,
    input logic             be_req,
    input logic             be_done
);

    localparam logic [1:0] OKAY  = 2'b00;
    localparam logic [1:0] RETRY = 2'b10;
    localparam logic [CNT_W:0] SAT = {(CNT_W+1){1'b1}};

    // Consecutive cycles of an outstanding, unfinished backend request
    logic [CNT_W:0] stalls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stalls_q <= '0;
        end else if (be_req && !be_done) begin
            if (stalls_q != SAT) stalls_q <= stalls_q + 1'b1;
        end else begin
            stalls_q <= '0;
        end
    end

    assert_retry_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (hresp == RETRY && !hreadyout) |=> (hresp == RETRY && hreadyout));

    assert_retry_tail_R2: assert property (@(posedge clk) disable iff (rst)
        (hresp == RETRY && hreadyout) |-> $past(hresp == RETRY && !hreadyout));

    assert_no_req_in_retry_R2: assert property (@(posedge clk) disable iff (rst)
        (hresp == RETRY) |-> !be_req);

    assert_wait_has_req_R3: assert property (@(posedge clk) disable iff (rst)
        (!hreadyout && hresp == OKAY) |-> be_req);

    assert_done_okay_R4: assert property (@(posedge clk) disable iff (rst)
        (be_req && be_done) |-> (hreadyout && hresp == OKAY));

    assert_stall_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_retry_en && be_req) |-> (stalls_q <= {1'b0, cfg_stall_limit}));

    assert_no_retry_waitonly_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_retry_en && be_req) |=> (hresp != RETRY));

    assert_reset_idle_R9: assert property (@(posedge clk)
        $fell(rst) |-> (hreadyout && hresp == OKAY && !be_req));

endmodule

bind ahb_retry_slave ahb_retry_slave_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_retry_en    (cfg_retry_en),
    .cfg_stall_limit (cfg_stall_limit),
    .hreadyout       (hreadyout),
    .hresp           (hresp),
    .be_req          (be_req),
    .be_done         (be_done)
);

// File: tb/ahb_retry_slave_test.sv
`timescale 1ns/1ps
module ahb_retry_slave_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam logic [1:0] OKAY  = 2'b00;
    localparam logic [1:0] RETRY = 2'b10;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_retry_en;
    logic [CW-1:0] cfg_stall_limit;
    logic          hsel;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic          hwrite;
    logic [DW-1:0] hwdata;
    logic          hready;
    logic          hreadyout;
    logic [1:0]    hresp;
    logic [DW-1:0] hrdata;
    logic          be_req;
    logic [AW-1:0] be_addr;
    logic          be_write;
    logic [DW-1:0] be_wdata;
    logic          be_busy;
    logic          be_done;
    logic [DW-1:0] be_rdata;

    always #4 clk = ~clk;  // 125 MHz

    assign hready = hreadyout;

    ahb_retry_slave #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cfg_retry_en(cfg_retry_en),
        .cfg_stall_limit(cfg_stall_limit), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .be_req(be_req), .be_addr(be_addr), .be_write(be_write),
        .be_wdata(be_wdata), .be_busy(be_busy), .be_done(be_done),
        .be_rdata(be_rdata)
    );

    typedef struct {
        logic [1:0]    resp;
        int            stalls;
        logic          want_rdata;
        logic [DW-1:0] rdata;
        string         req;
    } exp_t;

    exp_t expq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: counts wait and retry-lead cycles, compares at completion
    bit active = 0;
    int mon_stalls = 0;
    bit mon_lead = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (active) begin
                if (hreadyout) begin
                    active = 0;
                    if (expq.size() == 0) begin
                        check(0, "R4", "unexpected completion", 1, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check(hresp == e.resp, e.req, "final hresp", hresp, e.resp);
                        check(mon_stalls == e.stalls, e.req, "wait cycles", mon_stalls, e.stalls);
                        check(mon_lead == (e.resp == RETRY), e.req, "retry lead cycle",
                              mon_lead, e.resp == RETRY);
                        if (e.want_rdata)
                            check(hrdata == e.rdata, e.req, "hrdata", hrdata, e.rdata);
                    end
                end else if (hresp == OKAY) begin
                    mon_stalls++;
                end else if (hresp == RETRY) begin
                    mon_lead = 1;
                end
            end
            if (hsel && hready && htrans[1]) begin
                active = 1;
                mon_stalls = 0;
                mon_lead = 0;
            end
        end
    end

    // Driver: one transfer; lat = stalled cycles before be_done
    task automatic do_xfer(input logic [AW-1:0] a, input logic wr,
                           input logic [DW-1:0] wd, input logic busy,
                           input int lat, input string req);
        exp_t e;
        logic [DW-1:0] rd;
        int lim;
        rd  = a ^ 32'h5A5A_00C3;
        lim = int'(cfg_stall_limit);
        e.req = req;
        e.rdata = rd;
        e.want_rdata = 0;
        if (cfg_retry_en && busy) begin
            e.resp = RETRY; e.stalls = 0;
        end else if (cfg_retry_en && lat > lim) begin
            e.resp = RETRY; e.stalls = lim + 1;
        end else begin
            e.resp = OKAY; e.stalls = lat; e.want_rdata = !wr;
        end
        @(posedge clk); #1;
        hsel = 1; htrans = 2'b10; haddr = a; hwrite = wr; be_busy = busy; be_done = 0;
        expq.push_back(e);
        @(posedge clk); #1;
        hsel = 0; htrans = 2'b00; hwdata = wd; be_busy = 0; be_rdata = rd;
        for (int c = 0; c < 2000; c++) begin
            be_done = (c == lat);
            @(negedge clk);
            if (c == 0) begin
                if (e.resp == RETRY && e.stalls == 0) begin
                    check(be_req == 0, "R2", "be_req on busy retry", be_req, 0);
                    check(hresp == RETRY && !hreadyout, "R2", "lead cycle",
                          {hresp, hreadyout}, {RETRY, 1'b0});
                end else begin
                    check(be_req == 1, "R3", "be_req", be_req, 1);
                    check(be_addr == a, "R3", "be_addr", be_addr, a);
                    check(be_write == wr, "R8", "be_write", be_write, wr);
                    if (wr) check(be_wdata == wd, "R8", "be_wdata", be_wdata, wd);
                end
            end
            if (hreadyout) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        be_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        rst = 1; cfg_retry_en = 1; cfg_stall_limit = 8'd3;
        hsel = 0; haddr = '0; htrans = 2'b00; hwrite = 0; hwdata = '0;
        be_busy = 0; be_done = 0; be_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hreadyout && hresp == OKAY && !be_req, "R9", "reset outputs",
              {hreadyout, hresp, be_req}, {1'b1, OKAY, 1'b0});
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        check(hreadyout && hresp == OKAY && !be_req, "R9", "after reset",
              {hreadyout, hresp, be_req}, {1'b1, OKAY, 1'b0});

        // R1: BUSY type, IDLE type and unselected NONSEQ are not accepted
        @(posedge clk); #1; hsel = 1; htrans = 2'b01; haddr = 32'h100;
        @(posedge clk); #1; hsel = 1; htrans = 2'b00;
        @(posedge clk); #1; hsel = 0; htrans = 2'b10;
        @(posedge clk); #1; htrans = 2'b00;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(hreadyout && hresp == OKAY && !be_req, "R1", "no accept",
                  {hreadyout, hresp, be_req}, {1'b1, OKAY, 1'b0});
        end

        // R4: zero and short latency reads; R3 wait states
        do_xfer(32'h0000_1000, 0, '0, 0, 0, "R4");
        do_xfer(32'h0000_1004, 0, '0, 0, 2, "R3");
        // R8: write with data forwarding
        do_xfer(32'h0000_2000, 1, 32'hCAFE_F00D, 0, 1, "R8");
        // R2: busy at address phase
        do_xfer(32'h0000_3000, 0, '0, 1, 0, "R2");
        // R7: reissue after retry is fresh
        do_xfer(32'h0000_3000, 0, '0, 0, 3, "R7");
        // R5: boundary L and L+1 with L = 3
        do_xfer(32'h0000_4000, 0, '0, 0, 3, "R5");
        do_xfer(32'h0000_4004, 0, '0, 0, 4, "R5");
        do_xfer(32'h0000_4008, 0, '0, 0, 9, "R5");
        // R7: back-to-back transfers each with the full budget
        do_xfer(32'h0000_5000, 0, '0, 0, 3, "R7");
        do_xfer(32'h0000_5004, 1, 32'h1234_5678, 0, 3, "R7");
        // R5: limit zero
        cfg_stall_limit = 8'd0;
        do_xfer(32'h0000_6000, 0, '0, 0, 0, "R5");
        do_xfer(32'h0000_6004, 0, '0, 0, 1, "R5");
        // R6: wait-only mode ignores busy and never retries
        cfg_retry_en = 0; cfg_stall_limit = 8'd3;
        do_xfer(32'h0000_7000, 0, '0, 1, 2, "R6");
        do_xfer(32'h0000_7004, 0, '0, 0, 12, "R6");
        do_xfer(32'h0000_7008, 1, 32'hA5A5_0F0F, 1, 6, "R6");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R4", "responses outstanding", expq.size(), 0);
        summary();
    end

endmodule